// File: doc/BRIEF.md
# Interrupt Context Entry and Return Sequencer

This block carries out the memory traffic a 16-bit segmented processor needs when it takes an interrupt and when it leaves a handler. A one-cycle start strobe, together with an 8-bit interrupt type and the live FLAGS, CS, IP, SS and SP values, begins an entry sequence. The block saves three words on the stack and reads the handler address from a vector table at the bottom of memory. It then presents the handler CS:IP, the lowered stack pointer and a FLAGS value with interrupts and single-step turned off.

A separate return strobe begins the reverse sequence. Three words are read back from the stack, and the original IP, CS and FLAGS are presented with the stack pointer raised again. All memory traffic uses one 16-bit word port with a request/acknowledge handshake. A one-cycle done pulse marks that the new processor state is valid.

Top module: `irq_ctx_sequencer`

## Requirements
- R1: An entry writes three 16-bit words in this order: the original FLAGS at stack offset SP-2, then CS at SP-4, then IP at SP-6. Each write has mem_we_o = 1.
- R2: The FLAGS word written to the stack is the unmodified input. The FLAGS result of an entry is the input with bit 9 (interrupt enable) and bit 8 (trap) cleared and all other bits kept.
- R3: After its three writes, an entry reads the handler IP word at byte address type*4 and then the handler CS word at type*4+2. Every vector address lies below 1024 and is even.
- R4: At the end of an entry, new_ip_o and new_cs_o hold the two vector words and new_sp_o holds SP-6, taken modulo 2^16.
- R5: A stack access goes to physical address SS*16 + offset, truncated to 20 bits. The offset arithmetic wraps modulo 2^16.
- R6: A return reads IP at offset SP, then CS at SP+2, then FLAGS at SP+4. It then presents those three words, and new_sp_o holds SP+6.
- R7: Once mem_req_o is raised, it stays high with a stable address, write enable and write data until the cycle in which mem_ack_i is seen high. After that cycle it drops.
- R8: busy_o rises in the cycle after an accepted strobe and falls in the cycle done_o rises. start_i and ret_i arriving while busy_o is high cause no memory cycle and no done pulse. If both strobes arrive together while idle, only an entry is performed.
- R9: done_o is high for exactly one cycle per sequence. The four result outputs are valid in that cycle and held afterwards.
- R10: While reset is high, and in the first cycle after it, busy_o, done_o and mem_req_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an entry sequence (one-cycle strobe) |
| ret_i | input | 1 | Begin a return sequence (one-cycle strobe) |
| vtype_i | input | 8 | Interrupt type for an entry |
| flags_i | input | 16 | Current FLAGS |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 16 | Current instruction pointer |
| sp_i | input | 16 | Current stack pointer |
| ss_i | input | 16 | Current stack segment |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse: results valid |
| new_cs_o | output | 16 | Resulting code segment |
| new_ip_o | output | 16 | Resulting instruction pointer |
| new_sp_o | output | 16 | Resulting stack pointer |
| new_flags_o | output | 16 | Resulting FLAGS |
| mem_req_o | output | 1 | Memory cycle request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 20 | Physical byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with the acknowledge |
| mem_ack_i | input | 1 | Memory cycle complete |

## Verification
The bench aims at the address corners. A stack pointer of 2 makes the three pushes straddle the 16-bit wrap. A segment of FFFF makes the physical sum overflow 20 bits. Types 00 and FF hit both ends of the vector table. A design that carried the offset into the segment, or kept bit 20, would write the context to the wrong place, and the matching return would then restore garbage.

Strobes and changed inputs are injected while a sequence runs. A start-and-return collision is also tried, so a design that re-latches its inputs or accepts a second request shows up as extra bus cycles, wrong saved words or a second done pulse.

Acknowledge latency varies from zero to three cycles. A port that moves its address early, or that completes twice on one acknowledge, produces a mismatch against the queued expected cycles.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seq_state_t;
  typedef enum logic {MODE_ENTRY = 1'b0, MODE_RETURN = 1'b1} seq_mode_t;

  // FLAGS bits cleared on entry
  localparam int IE_BIT   = 9;
  localparam int TRAP_BIT = 8;
  // number of words saved on the stack, and index of the last step per mode
  localparam int PUSHES      = 3;
  localparam int ENTRY_LAST  = 4;
  localparam int RETURN_LAST = 2;
endpackage

// File: rtl/irq_addr_calc.sv
module irq_addr_calc
  import irq_seq_pkg::*;
#(
  parameter int AW        = 20,
  parameter int WW        = 16,
  parameter int TW        = 8,
  parameter int SEG_SHIFT = 4,
  parameter int STEP_W    = 3
) (
  input  seq_mode_t         mode_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [WW-1:0]     ss_i,
  input  logic [WW-1:0]     sp_i,
  input  logic [TW-1:0]     vtype_i,
  output logic [AW-1:0]     addr_o,
  output logic              we_o
);
  localparam int BYTES     = WW / 8;
  localparam int VEC_SHIFT = $clog2(2 * BYTES);
  localparam int SUM_W     = WW + SEG_SHIFT;
  localparam logic [STEP_W-1:0] LAST_E  = STEP_W'(ENTRY_LAST);
  localparam logic [STEP_W-1:0] NPUSH   = STEP_W'(PUSHES);

  logic [WW-1:0]    stk_off;
  logic [SUM_W-1:0] stk_sum;
  logic [AW-1:0]    vec_addr;
  logic             is_vec;

  always_comb begin
    // offset arithmetic stays inside 16 bits (R5)
    if (mode_i == MODE_ENTRY)
      stk_off = sp_i - (WW'(step_i) + WW'(1)) * WW'(BYTES);
    else
      stk_off = sp_i + WW'(step_i) * WW'(BYTES);
    stk_sum  = {ss_i, {SEG_SHIFT{1'b0}}} + SUM_W'(stk_off);
    vec_addr = AW'({vtype_i, {VEC_SHIFT{1'b0}}})
             + ((step_i == LAST_E) ? AW'(BYTES) : AW'(0));
    is_vec   = (mode_i == MODE_ENTRY) && (step_i >= NPUSH);
    we_o     = (mode_i == MODE_ENTRY) && (step_i < NPUSH);
    addr_o   = is_vec ? vec_addr : AW'(stk_sum);
  end
endmodule

// File: rtl/irq_bus_port.sv
module irq_bus_port #(
  parameter int AW = 20,
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [WW-1:0] wdata_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [WW-1:0] mem_wdata_o,
  input  logic [WW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  output logic          fin_o,
  output logic [WW-1:0] rdata_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      fin_o       <= 1'b0;
      rdata_o     <= '0;
    end else begin
      fin_o <= 1'b0;
      if (mem_req_o && mem_ack_i) begin
        mem_req_o <= 1'b0;
        fin_o     <= 1'b1;
        rdata_o   <= mem_rdata_i;
      end else if (go_i && !mem_req_o) begin
        mem_req_o   <= 1'b1;
        mem_we_o    <= we_i;
        mem_addr_o  <= addr_i;
        mem_wdata_o <= wdata_i;
      end
    end
  end

  // R7: a pending request keeps its attributes until acknowledged
  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                   && $stable(mem_we_o) && $stable(mem_wdata_o)));
  // R7: an acknowledged request drops and completes once
  p_ack_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_ack_i) |=> (!mem_req_o && fin_o));
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int WW     = 16,
  parameter int TW     = 8,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              ret_i,
  input  logic [TW-1:0]     vtype_i,
  input  logic [WW-1:0]     flags_i,
  input  logic [WW-1:0]     cs_i,
  input  logic [WW-1:0]     ip_i,
  input  logic [WW-1:0]     sp_i,
  input  logic [WW-1:0]     ss_i,
  input  logic              fin_i,
  input  logic [WW-1:0]     rdata_i,
  output logic              go_o,
  output seq_mode_t         mode_o,
  output logic [STEP_W-1:0] step_o,
  output logic [WW-1:0]     ss_o,
  output logic [WW-1:0]     sp_o,
  output logic [TW-1:0]     vtype_o,
  output logic [WW-1:0]     wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [WW-1:0]     new_cs_o,
  output logic [WW-1:0]     new_ip_o,
  output logic [WW-1:0]     new_sp_o,
  output logic [WW-1:0]     new_flags_o
);
  localparam int BYTES = WW / 8;
  localparam logic [WW-1:0] SP_SPAN  = WW'(BYTES * PUSHES);
  localparam logic [WW-1:0] FLAG_CLR = ~((WW'(1) << IE_BIT) | (WW'(1) << TRAP_BIT));
  localparam logic [STEP_W-1:0] LAST_E = STEP_W'(ENTRY_LAST);
  localparam logic [STEP_W-1:0] LAST_R = STEP_W'(RETURN_LAST);
  localparam logic [STEP_W-1:0] VEC_IP = STEP_W'(PUSHES);

  seq_state_t        state_q;
  seq_mode_t         mode_q;
  logic [STEP_W-1:0] step_q;
  logic [WW-1:0]     flags_q, cs_q, ip_q, sp_q, ss_q;
  logic [TW-1:0]     vtype_q;
  logic [WW-1:0]     tmp_ip_q, tmp_cs_q;
  logic              last_step;

  assign go_o    = (state_q == ST_ISSUE);
  assign mode_o  = mode_q;
  assign step_o  = step_q;
  assign ss_o    = ss_q;
  assign sp_o    = sp_q;
  assign vtype_o = vtype_q;
  assign last_step = (mode_q == MODE_ENTRY) ? (step_q == LAST_E) : (step_q == LAST_R);

  always_comb begin
    unique case (step_q)
      STEP_W'(0): wdata_o = flags_q;
      STEP_W'(1): wdata_o = cs_q;
      default:    wdata_o = ip_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      mode_q      <= MODE_ENTRY;
      step_q      <= '0;
      flags_q     <= '0;
      cs_q        <= '0;
      ip_q        <= '0;
      sp_q        <= '0;
      ss_q        <= '0;
      vtype_q     <= '0;
      tmp_ip_q    <= '0;
      tmp_cs_q    <= '0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      new_cs_o    <= '0;
      new_ip_o    <= '0;
      new_sp_o    <= '0;
      new_flags_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i || ret_i) begin
            mode_q  <= start_i ? MODE_ENTRY : MODE_RETURN;
            step_q  <= '0;
            flags_q <= flags_i;
            cs_q    <= cs_i;
            ip_q    <= ip_i;
            sp_q    <= sp_i;
            ss_q    <= ss_i;
            vtype_q <= vtype_i;
            busy_o  <= 1'b1;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (fin_i) begin
            if (mode_q == MODE_ENTRY) begin
              if (step_q == VEC_IP) tmp_ip_q <= rdata_i;
            end else begin
              if (step_q == STEP_W'(0)) tmp_ip_q <= rdata_i;
              if (step_q == STEP_W'(1)) tmp_cs_q <= rdata_i;
            end
            if (last_step) begin
              if (mode_q == MODE_ENTRY) begin
                new_ip_o    <= tmp_ip_q;
                new_cs_o    <= rdata_i;
                new_sp_o    <= sp_q - SP_SPAN;
                new_flags_o <= flags_q & FLAG_CLR;
              end else begin
                new_ip_o    <= tmp_ip_q;
                new_cs_o    <= tmp_cs_q;
                new_sp_o    <= sp_q + SP_SPAN;
                new_flags_o <= rdata_i;
              end
              done_o  <= 1'b1;
              busy_o  <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              step_q  <= step_q + STEP_W'(1);
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R8: busy ends exactly when done is raised
  p_busy_done_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $fell(busy_o));
  // R8: an idle strobe is accepted on the next edge
  p_start_busy_r8: assert property (@(posedge clk) disable iff (rst)
    ((start_i || ret_i) && !busy_o) |=> busy_o);
  // R2: entry result never leaves interrupts or trap enabled
  p_entry_flags_r2: assert property (@(posedge clk) disable iff (rst)
    (done_o && mode_q == MODE_ENTRY) |-> (new_flags_o[IE_BIT] == 1'b0 && new_flags_o[TRAP_BIT] == 1'b0));
  // R4: entry result lowers the stack by the saved span
  p_entry_sp_r4: assert property (@(posedge clk) disable iff (rst)
    (done_o && mode_q == MODE_ENTRY) |-> (new_sp_o + SP_SPAN == sp_q));
endmodule

// File: rtl/irq_ctx_sequencer.sv
module irq_ctx_sequencer
  import irq_seq_pkg::*;
#(
  parameter int AW        = 20,
  parameter int WW        = 16,
  parameter int TW        = 8,
  parameter int SEG_SHIFT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          ret_i,
  input  logic [TW-1:0] vtype_i,
  input  logic [WW-1:0] flags_i,
  input  logic [WW-1:0] cs_i,
  input  logic [WW-1:0] ip_i,
  input  logic [WW-1:0] sp_i,
  input  logic [WW-1:0] ss_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [WW-1:0] new_cs_o,
  output logic [WW-1:0] new_ip_o,
  output logic [WW-1:0] new_sp_o,
  output logic [WW-1:0] new_flags_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [WW-1:0] mem_wdata_o,
  input  logic [WW-1:0] mem_rdata_i,
  input  logic          mem_ack_i
);
  localparam int STEP_W = $clog2(ENTRY_LAST + 1);
  localparam logic [AW-1:0] VEC_LIMIT = AW'((2 * WW / 8) << TW);

  logic              go_w, we_w, fin_w;
  seq_mode_t         mode_w;
  logic [STEP_W-1:0] step_w;
  logic [WW-1:0]     ss_w, sp_w, wdata_w, rdata_w;
  logic [TW-1:0]     vtype_w;
  logic [AW-1:0]     addr_w;

  irq_seq_ctrl #(.WW(WW), .TW(TW), .STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .ret_i(ret_i),
    .vtype_i(vtype_i), .flags_i(flags_i), .cs_i(cs_i), .ip_i(ip_i),
    .sp_i(sp_i), .ss_i(ss_i), .fin_i(fin_w), .rdata_i(rdata_w),
    .go_o(go_w), .mode_o(mode_w), .step_o(step_w), .ss_o(ss_w),
    .sp_o(sp_w), .vtype_o(vtype_w), .wdata_o(wdata_w),
    .busy_o(busy_o), .done_o(done_o), .new_cs_o(new_cs_o),
    .new_ip_o(new_ip_o), .new_sp_o(new_sp_o), .new_flags_o(new_flags_o)
  );

  irq_addr_calc #(.AW(AW), .WW(WW), .TW(TW), .SEG_SHIFT(SEG_SHIFT), .STEP_W(STEP_W)) u_addr (
    .mode_i(mode_w), .step_i(step_w), .ss_i(ss_w), .sp_i(sp_w),
    .vtype_i(vtype_w), .addr_o(addr_w), .we_o(we_w)
  );

  irq_bus_port #(.AW(AW), .WW(WW)) u_port (
    .clk(clk), .rst(rst), .go_i(go_w), .we_i(we_w), .addr_i(addr_w),
    .wdata_i(wdata_w), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
    .fin_o(fin_w), .rdata_o(rdata_w)
  );

  // R8: no bus traffic while idle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !mem_req_o);
  // R3: entry reads stay inside the even-aligned vector window
  p_vec_window_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_we_o && mode_w == MODE_ENTRY) |-> (mem_addr_o < VEC_LIMIT && mem_addr_o[0] == 1'b0));
endmodule

// File: tb/test_irq_ctx_sequencer.sv
`timescale 1ns/1ps
module test_irq_ctx_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, ret_i = 1'b0;
  logic [7:0]  vtype_i = '0;
  logic [15:0] flags_i = '0, cs_i = '0, ip_i = '0, sp_i = '0, ss_i = '0;
  logic        busy_o, done_o, mem_req_o, mem_we_o;
  logic [15:0] new_cs_o, new_ip_o, new_sp_o, new_flags_o, mem_wdata_o;
  logic [19:0] mem_addr_o;
  logic [15:0] mem_rdata_i = '0;
  logic        mem_ack_i = 1'b0;

  always #10 clk = ~clk;

  irq_ctx_sequencer i_irq_ctx_sequencer (
    .clk(clk), .rst(rst), .start_i(start_i), .ret_i(ret_i), .vtype_i(vtype_i),
    .flags_i(flags_i), .cs_i(cs_i), .ip_i(ip_i), .sp_i(sp_i), .ss_i(ss_i),
    .busy_o(busy_o), .done_o(done_o), .new_cs_o(new_cs_o), .new_ip_o(new_ip_o),
    .new_sp_o(new_sp_o), .new_flags_o(new_flags_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i)
  );

  typedef struct packed { logic we; logic [19:0] addr; logic [15:0] data; } op_t;
  typedef struct packed { logic [15:0] cs, ip, sp, fl; logic entry; } res_t;

  op_t   exp_ops[$];
  string exp_tag[$];
  res_t  exp_res[$];
  logic [15:0] mem [logic [19:0]];

  int errors = 0, checks = 0, done_seen = 0, txn_no = 0, wait_left = 0;
  bit in_txn = 0, prev_done = 0;
  op_t hold;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
    return {seg, 4'h0} + 20'(off);
  endfunction
  function automatic logic [15:0] vip(input logic [7:0] t);
    return {8'h40, t} ^ 16'h0A0A;
  endfunction
  function automatic logic [15:0] vcs(input logic [7:0] t);
    return {t, 8'hC3};
  endfunction

  // memory model and scoreboard monitor, both away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      mem_ack_i = 1'b0;
      in_txn = 1'b0;
    end else begin
      if (mem_ack_i) mem_ack_i = 1'b0;
      else if (mem_req_o) begin
        if (!in_txn) begin
          in_txn = 1'b1;
          wait_left = txn_no % 4;
          hold = '{mem_we_o, mem_addr_o, mem_wdata_o};
        end
        if (wait_left == 0) begin
          chk(mem_addr_o == hold.addr && mem_we_o == hold.we && mem_wdata_o == hold.data,
              "R7", "request held", {12'h0, mem_addr_o}, {12'h0, hold.addr});
          if (mem_we_o) mem[mem_addr_o] = mem_wdata_o;
          else mem_rdata_i = mem.exists(mem_addr_o) ? mem[mem_addr_o] : 16'hDEAD;
          if (exp_ops.size() == 0) begin
            chk(1'b0, "R8", "unexpected bus cycle", {12'h0, mem_addr_o}, 32'h0);
          end else begin
            op_t e;
            string tg;
            e = exp_ops.pop_front();
            tg = exp_tag.pop_front();
            chk(mem_we_o == e.we && mem_addr_o == e.addr && (!e.we || mem_wdata_o == e.data),
                tg, "bus cycle we/addr/data", {mem_we_o, 11'h0, mem_addr_o} ^ 32'h0,
                {e.we, 11'h0, e.addr});
            if (e.we)
              chk(mem_wdata_o == e.data, tg, "write data", {16'h0, mem_wdata_o}, {16'h0, e.data});
          end
          mem_ack_i = 1'b1;
          in_txn = 1'b0;
          txn_no++;
        end else wait_left--;
      end
      if (done_o) begin
        chk(!prev_done, "R9", "done pulse width", 32'd1, 32'd0);
        chk(!busy_o, "R8", "busy low at done", {31'h0, busy_o}, 32'h0);
        if (exp_res.size() == 0) chk(1'b0, "R9", "unexpected done", 32'h1, 32'h0);
        else begin
          res_t r;
          r = exp_res.pop_front();
          if (r.entry) begin
            chk(new_cs_o == r.cs && new_ip_o == r.ip, "R4", "handler CS:IP",
                {new_cs_o, new_ip_o}, {r.cs, r.ip});
            chk(new_sp_o == r.sp, "R4", "entry SP", {16'h0, new_sp_o}, {16'h0, r.sp});
            chk(new_flags_o == r.fl, "R2", "entry FLAGS", {16'h0, new_flags_o}, {16'h0, r.fl});
          end else begin
            chk(new_cs_o == r.cs && new_ip_o == r.ip && new_flags_o == r.fl, "R6",
                "restored CS:IP", {new_cs_o, new_ip_o}, {r.cs, r.ip});
            chk(new_flags_o == r.fl, "R6", "restored FLAGS", {16'h0, new_flags_o}, {16'h0, r.fl});
            chk(new_sp_o == r.sp, "R6", "return SP", {16'h0, new_sp_o}, {16'h0, r.sp});
          end
        end
        done_seen++;
      end
      prev_done = done_o;
    end
  end

  task automatic push_op(input logic we, input logic [19:0] a, input logic [15:0] d, input string tg);
    exp_ops.push_back('{we, a, d});
    exp_tag.push_back(tg);
  endtask

  task automatic quiet_check(input int tgt);
    repeat (8) @(negedge clk);
    chk(exp_ops.size() == 0, "R8", "leftover expected cycles", exp_ops.size(), 0);
    chk(done_seen == tgt, "R8", "done count", done_seen, tgt);
    chk(!busy_o && !mem_req_o, "R9", "idle after sequence", {busy_o, mem_req_o}, 0);
  endtask

  task automatic do_entry(input logic [7:0] t, input logic [15:0] f, c, i, s, g,
                          input bit noisy, input bit with_ret, input string stk_tag);
    int tgt;
    tgt = done_seen + 1;
    push_op(1'b1, phys(g, s - 16'd2), f, stk_tag);   // R1 FLAGS first
    push_op(1'b1, phys(g, s - 16'd4), c, stk_tag);   // R1 then CS
    push_op(1'b1, phys(g, s - 16'd6), i, stk_tag);   // R1 then IP
    push_op(1'b0, 20'(t) << 2, 16'h0, "R3");
    push_op(1'b0, (20'(t) << 2) + 20'd2, 16'h0, "R3");
    exp_res.push_back('{vcs(t), vip(t), s - 16'd6, f & 16'hFCFF, 1'b1});
    @(negedge clk);
    start_i = 1'b1; ret_i = with_ret; vtype_i = t;
    flags_i = f; cs_i = c; ip_i = i; sp_i = s; ss_i = g;
    @(negedge clk);
    start_i = 1'b0; ret_i = 1'b0;
    if (noisy) begin
      start_i = 1'b1; ret_i = 1'b1; vtype_i = t ^ 8'h55;
      flags_i = ~f; cs_i = ~c; ip_i = ~i; sp_i = s + 16'h40; ss_i = ~g;
      repeat (2) @(negedge clk);
      start_i = 1'b0; ret_i = 1'b0;
    end
    wait (done_seen == tgt);
    quiet_check(tgt);
  endtask

  task automatic do_return(input logic [15:0] s, g, c, i, f, input bit noisy);
    int tgt;
    tgt = done_seen + 1;
    push_op(1'b0, phys(g, s), 16'h0, "R6");
    push_op(1'b0, phys(g, s + 16'd2), 16'h0, "R6");
    push_op(1'b0, phys(g, s + 16'd4), 16'h0, "R6");
    exp_res.push_back('{c, i, s + 16'd6, f, 1'b0});
    @(negedge clk);
    ret_i = 1'b1; sp_i = s; ss_i = g;
    @(negedge clk);
    ret_i = 1'b0;
    if (noisy) begin
      start_i = 1'b1; vtype_i = 8'h01; sp_i = 16'h1234;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait (done_seen == tgt);
    quiet_check(tgt);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    for (int t = 0; t < 256; t++) begin
      mem[20'(t) << 2]          = vip(8'(t));
      mem[(20'(t) << 2) + 20'd2] = vcs(8'(t));
    end
    repeat (2) @(negedge clk);
    chk(!busy_o && !done_o && !mem_req_o, "R10", "outputs in reset",
        {busy_o, done_o, mem_req_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && !mem_req_o, "R10", "outputs after reset",
        {busy_o, done_o, mem_req_o}, 0);

    // R1 R2 R3 R4 R8: ordinary entry with strobes injected while busy
    do_entry(8'h21, 16'h0302, 16'h1234, 16'h5678, 16'h0100, 16'h2000, 1'b1, 1'b0, "R1");
    // R6: return restores what the entry saved
    do_return(16'h00FA, 16'h2000, 16'h1234, 16'h5678, 16'h0302, 1'b1);
    // R3: lowest vector, all flags set
    do_entry(8'h00, 16'hFFFF, 16'h0001, 16'hFFFE, 16'h8000, 16'h0000, 1'b0, 1'b0, "R1");
    // R3: highest vector, no flags
    do_entry(8'hFF, 16'h0000, 16'hABCD, 16'h0042, 16'h4000, 16'h0300, 1'b0, 1'b0, "R1");
    // R5: stack offset wraps below zero
    do_entry(8'h7F, 16'h0200, 16'h1111, 16'h2222, 16'h0002, 16'h1000, 1'b0, 1'b0, "R5");
    do_return(16'hFFFC, 16'h1000, 16'h1111, 16'h2222, 16'h0200, 1'b0);
    // R5: physical sum truncated to 20 bits
    do_entry(8'h10, 16'h0100, 16'h3333, 16'h4444, 16'h0020, 16'hFFFF, 1'b0, 1'b0, "R5");
    do_return(16'h001A, 16'hFFFF, 16'h3333, 16'h4444, 16'h0100, 1'b0);
    // R8: start and return together while idle: entry wins
    do_entry(8'h33, 16'h0F00, 16'h5555, 16'h6666, 16'h2000, 16'h0700, 1'b0, 1'b1, "R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule